// File: doc/BRIEF.md
# Multicycle Load/Store Processor Datapath

This block is the storage and steering half of a 32-bit load/store processor that spends several clock cycles on each instruction. One ALU and one memory port serve every step of an instruction. Selectors choose what reaches them in a given cycle, and holding registers keep values from one cycle to the next. The block contains the program counter, the instruction register, a memory data register, two operand latches, an ALU result latch and a 32-entry register file.

A separate sequencer drives every select and write-enable input once per cycle. The datapath returns the opcode of the held instruction and a flag that is high when the live ALU result is zero, and the sequencer uses these to choose its next step. The single memory port carries instruction fetches and data accesses. Read data is expected to be valid in the same cycle as the address.

Top module: `mc_datapath`

## Requirements
- R1: While `rst_n` is low, the PC, IR, MDR, A, B, ALUOut and all registers are cleared. After release, with idle controls, `mem_addr` is 0, `opcode` is 0, `mem_wdata` is 0 and `zero` is 1.
- R2: `opa_sel` chooses the ALU first operand: 0 selects the PC and 1 selects the A latch.
- R3: `opb_sel` chooses the ALU second operand with this encoding: 00 selects the B latch, 01 the constant 4, 10 the sign-extended IR[15:0], and 11 the sign-extended IR[15:0] shifted left by two.
- R4: `alu_mode` 00 adds and 01 subtracts (first minus second). Codes 10 and 11 decode IR[5:0]: 0x20 add, 0x22 subtract, 0x24 AND, 0x25 OR, 0x26 XOR, 0x27 NOR, 0x2A signed set-less-than. Any other value adds. `zero` is high exactly when the live ALU result is 0.
- R5: `addr_sel` 0 places the PC on `mem_addr` and 1 places ALUOut there. `mem_wdata` is the B latch. `mem_re` and `mem_we` follow `mem_rd` and `mem_wr` in the same cycle.
- R6: The IR captures `mem_rdata` at a clock edge only when `ir_we` is high, and otherwise holds its value. `opcode` is IR[31:26].
- R7: The PC loads at an edge when `pc_we` is high, or when `pc_we_cond` is high and `zero` is high. The source depends on `pc_src`: 00 is the live ALU result, 01 is ALUOut, 10 is the jump address {PC[31:28], IR[25:0], 2'b00}, and 11 is the live ALU result.
- R8: A register write under `rf_we` goes to IR[20:16] when `dst_sel` is 0 and to IR[15:11] when it is 1. The data is ALUOut when `wb_sel` is 0 and MDR when it is 1. A reads the register named by IR[25:21] and B reads the one named by IR[20:16]. Other registers keep their values.
- R9: Register 0 always reads as zero, and a write to it has no effect.
- R10: MDR, A, B and ALUOut load at every clock edge without an enable, from `mem_rdata`, the two register reads and the live ALU result respectively.
- R11: A negative 16-bit immediate is sign-extended to 32 bits before it reaches the ALU, so it can reach an address below the base register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pc_we | input | 1 | Unconditional PC load |
| pc_we_cond | input | 1 | PC load when the ALU result is zero |
| ir_we | input | 1 | Instruction register load |
| addr_sel | input | 1 | Memory address source: 0 PC, 1 ALUOut |
| mem_rd | input | 1 | Memory read request |
| mem_wr | input | 1 | Memory write request |
| wb_sel | input | 1 | Register write data: 0 ALUOut, 1 MDR |
| dst_sel | input | 1 | Register write target: 0 IR[20:16], 1 IR[15:11] |
| rf_we | input | 1 | Register file write enable |
| opa_sel | input | 1 | ALU first operand: 0 PC, 1 A |
| opb_sel | input | 2 | ALU second operand select |
| alu_mode | input | 2 | ALU operation class |
| pc_src | input | 2 | Next PC source |
| mem_rdata | input | 32 | Memory read data |
| mem_addr | output | 32 | Memory address |
| mem_wdata | output | 32 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_we | output | 1 | Memory write strobe |
| opcode | output | 6 | Opcode field of the held instruction |
| zero | output | 1 | Live ALU result equals zero |

## Verification
The bench builds the block with its default values: a 32-bit word and 32 registers. At these values every 5-bit register field selects a real register, and the jump address has exactly four PC bits above the 26-bit target field, so the target field and the retained PC bits can both be checked. The bench models a word-addressed memory and acts as the sequencer for loads, stores, every register-to-register function, taken and untaken branches and a jump. It stores each result back out and checks the store data and address on the memory port.

// File: rtl/mc_dp_pkg.sv
package mc_dp_pkg;

    localparam int unsigned FIELD_W = 5;

    typedef enum logic [1:0] {
        OPB_REG    = 2'b00,
        OPB_FOUR   = 2'b01,
        OPB_IMM    = 2'b10,
        OPB_IMM_SH = 2'b11
    } opb_sel_e;

    typedef enum logic [1:0] {
        PCS_ALU    = 2'b00,
        PCS_TARGET = 2'b01,
        PCS_JUMP   = 2'b10,
        PCS_ALT    = 2'b11
    } pc_src_e;

    typedef enum logic [1:0] {
        AM_ADD   = 2'b00,
        AM_SUB   = 2'b01,
        AM_FUNC  = 2'b10,
        AM_FUNC2 = 2'b11
    } alu_mode_e;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_AND = 3'd2,
        OP_OR  = 3'd3,
        OP_XOR = 3'd4,
        OP_NOR = 3'd5,
        OP_SLT = 3'd6
    } alu_op_e;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_AND = 6'h24;
    localparam logic [5:0] FN_OR  = 6'h25;
    localparam logic [5:0] FN_XOR = 6'h26;
    localparam logic [5:0] FN_NOR = 6'h27;
    localparam logic [5:0] FN_SLT = 6'h2A;

endpackage

// File: rtl/mc_alu_ctrl.sv
module mc_alu_ctrl
    import mc_dp_pkg::*;
(
    input  logic [1:0] mode,
    input  logic [5:0] funct,
    output alu_op_e    op
);

    always_comb begin
        unique case (alu_mode_e'(mode))
            AM_ADD: op = OP_ADD;
            AM_SUB: op = OP_SUB;
            default: begin
                unique case (funct)
                    FN_SUB:  op = OP_SUB;
                    FN_AND:  op = OP_AND;
                    FN_OR:   op = OP_OR;
                    FN_XOR:  op = OP_XOR;
                    FN_NOR:  op = OP_NOR;
                    FN_SLT:  op = OP_SLT;
                    default: op = OP_ADD;
                endcase
            end
        endcase
    end

endmodule

// File: rtl/mc_alu.sv
module mc_alu
    import mc_dp_pkg::*;
#(
    parameter int unsigned XLEN = 32
) (
    input  logic [XLEN-1:0] opa,
    input  logic [XLEN-1:0] opb,
    input  alu_op_e         op,
    output logic [XLEN-1:0] y,
    output logic            is_zero
);

    logic lt_signed;

    always_comb begin
        lt_signed = $signed(opa) < $signed(opb);
        unique case (op)
            OP_SUB:  y = opa - opb;
            OP_AND:  y = opa & opb;
            OP_OR:   y = opa | opb;
            OP_XOR:  y = opa ^ opb;
            OP_NOR:  y = ~(opa | opb);
            OP_SLT:  y = {{(XLEN-1){1'b0}}, lt_signed};
            default: y = opa + opb;
        endcase
        is_zero = (y == '0);
    end

endmodule

// File: rtl/mc_regfile.sv
module mc_regfile
    import mc_dp_pkg::*;
#(
    parameter int unsigned XLEN   = 32,
    parameter int unsigned NREGS  = 32,
    parameter int unsigned NREAD  = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [FIELD_W-1:0]            waddr,
    input  logic [XLEN-1:0]               wdata,
    input  logic [NREAD-1:0][FIELD_W-1:0] raddr,
    output logic [NREAD-1:0][XLEN-1:0]    rdata
);

    localparam int unsigned RF_AW = $clog2(NREGS);

    logic [XLEN-1:0] regs_q [NREGS];
    logic [XLEN-1:0] regs_d [NREGS];

    always_comb begin
        regs_d = regs_q;
        if (we && (waddr[RF_AW-1:0] != '0)) begin
            regs_d[waddr[RF_AW-1:0]] = wdata;
        end
        regs_d[0] = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{default: '0};
        end else begin
            regs_q <= regs_d;
        end
    end

    for (genvar p = 0; p < NREAD; p++) begin : g_rd
        assign rdata[p] = (raddr[p][RF_AW-1:0] == '0) ? '0 : regs_q[raddr[p][RF_AW-1:0]];
    end

endmodule

// File: rtl/mc_datapath.sv
module mc_datapath
    import mc_dp_pkg::*;
#(
    parameter int unsigned XLEN  = 32,
    parameter int unsigned NREGS = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pc_we,
    input  logic            pc_we_cond,
    input  logic            ir_we,
    input  logic            addr_sel,
    input  logic            mem_rd,
    input  logic            mem_wr,
    input  logic            wb_sel,
    input  logic            dst_sel,
    input  logic            rf_we,
    input  logic            opa_sel,
    input  logic [1:0]      opb_sel,
    input  logic [1:0]      alu_mode,
    input  logic [1:0]      pc_src,
    input  logic [XLEN-1:0] mem_rdata,
    output logic [XLEN-1:0] mem_addr,
    output logic [XLEN-1:0] mem_wdata,
    output logic            mem_re,
    output logic            mem_we,
    output logic [5:0]      opcode,
    output logic            zero
);

    localparam int unsigned IMM_W    = 16;
    localparam int unsigned TGT_W    = 26;
    localparam int unsigned PC_KEEP  = XLEN - TGT_W - 2;

    typedef struct packed {
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] ir;
        logic [XLEN-1:0] mdr;
        logic [XLEN-1:0] a;
        logic [XLEN-1:0] b;
        logic [XLEN-1:0] alu_out;
    } dp_state_t;

    dp_state_t state_d, state_q;

    logic [XLEN-1:0] pc_q, ir_q, mdr_q, a_q, b_q, alu_out_q;
    logic [XLEN-1:0] opa_val, opb_val, imm_sx, imm_sh, jump_addr, pc_next;
    logic [XLEN-1:0] alu_y, rf_wdata;
    logic            alu_zero, pc_load;
    logic [FIELD_W-1:0] rs_f, rt_f, rd_f, rf_waddr;
    logic [1:0][FIELD_W-1:0] rf_raddr;
    logic [1:0][XLEN-1:0]    rf_rdata;
    alu_op_e         alu_op;

    assign pc_q      = state_q.pc;
    assign ir_q      = state_q.ir;
    assign mdr_q     = state_q.mdr;
    assign a_q       = state_q.a;
    assign b_q       = state_q.b;
    assign alu_out_q = state_q.alu_out;

    assign rs_f = ir_q[25:21];
    assign rt_f = ir_q[20:16];
    assign rd_f = ir_q[15:11];

    // Operand steering and address forms
    always_comb begin
        imm_sx    = {{(XLEN-IMM_W){ir_q[IMM_W-1]}}, ir_q[IMM_W-1:0]};
        imm_sh    = {imm_sx[XLEN-3:0], 2'b00};
        jump_addr = {pc_q[XLEN-1:XLEN-PC_KEEP], ir_q[TGT_W-1:0], 2'b00};
        opa_val   = opa_sel ? a_q : pc_q;
        unique case (opb_sel_e'(opb_sel))
            OPB_REG:    opb_val = b_q;
            OPB_FOUR:   opb_val = XLEN'(4);
            OPB_IMM:    opb_val = imm_sx;
            default:    opb_val = imm_sh;
        endcase
    end

    mc_alu_ctrl u_alu_ctrl (
        .mode  (alu_mode),
        .funct (ir_q[5:0]),
        .op    (alu_op)
    );

    mc_alu #(.XLEN(XLEN)) u_alu (
        .opa     (opa_val),
        .opb     (opb_val),
        .op      (alu_op),
        .y       (alu_y),
        .is_zero (alu_zero)
    );

    // Register file write steering
    always_comb begin
        rf_waddr    = dst_sel ? rd_f : rt_f;
        rf_wdata    = wb_sel ? mdr_q : alu_out_q;
        rf_raddr[0] = rs_f;
        rf_raddr[1] = rt_f;
    end

    mc_regfile #(.XLEN(XLEN), .NREGS(NREGS), .NREAD(2)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (rf_we),
        .waddr (rf_waddr),
        .wdata (rf_wdata),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    // Next-state computation
    always_comb begin
        unique case (pc_src_e'(pc_src))
            PCS_TARGET: pc_next = alu_out_q;
            PCS_JUMP:   pc_next = jump_addr;
            default:    pc_next = alu_y;
        endcase
        pc_load = pc_we | (pc_we_cond & alu_zero);

        state_d         = state_q;
        state_d.pc      = pc_load ? pc_next : pc_q;
        state_d.ir      = ir_we ? mem_rdata : ir_q;
        state_d.mdr     = mem_rdata;
        state_d.a       = rf_rdata[0];
        state_d.b       = rf_rdata[1];
        state_d.alu_out = alu_y;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign mem_addr  = addr_sel ? alu_out_q : pc_q;
    assign mem_wdata = b_q;
    assign mem_re    = mem_rd;
    assign mem_we    = mem_wr;
    assign opcode    = ir_q[XLEN-1:XLEN-6];
    assign zero      = alu_zero;

endmodule

// File: rtl/mc_dp_checker.sv
module mc_dp_checker #(
    parameter int unsigned XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            pc_we,
    input logic            pc_we_cond,
    input logic            ir_we,
    input logic            opa_sel,
    input logic [1:0]      opb_sel,
    input logic [1:0]      alu_mode,
    input logic [1:0]      pc_src,
    input logic            mem_re,
    input logic [XLEN-1:0] mem_rdata,
    input logic            zero,
    input logic [XLEN-1:0] pc_q,
    input logic [XLEN-1:0] ir_q,
    input logic [XLEN-1:0] mdr_q,
    input logic [XLEN-1:0] rs_data
);

    a_r6_ir_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !ir_we |=> (ir_q == $past(ir_q)));

    a_r6_ir_load: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |=> (ir_q == $past(mem_rdata)));

    a_r7_cond_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we_cond && !pc_we && !zero) |=> (pc_q == $past(pc_q)));

    a_r7_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_we && pc_src == 2'b00 && !opa_sel && opb_sel == 2'b01 && alu_mode == 2'b00)
        |=> (pc_q == $past(pc_q) + XLEN'(4)));

    a_r9_reg0_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (ir_q[25:21] == 5'd0) |-> (rs_data == '0));

    a_r10_mdr_capture: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> (mdr_q == $past(mem_rdata)));

endmodule

bind mc_datapath mc_dp_checker #(.XLEN(XLEN)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pc_we      (pc_we),
    .pc_we_cond (pc_we_cond),
    .ir_we      (ir_we),
    .opa_sel    (opa_sel),
    .opb_sel    (opb_sel),
    .alu_mode   (alu_mode),
    .pc_src     (pc_src),
    .mem_re     (mem_re),
    .mem_rdata  (mem_rdata),
    .zero       (zero),
    .pc_q       (pc_q),
    .ir_q       (ir_q),
    .mdr_q      (mdr_q),
    .rs_data    (rf_rdata[0])
);

// File: tb/mc_datapath_tb_top.sv
module mc_datapath_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pc_we, pc_we_cond, ir_we, addr_sel, mem_rd, mem_wr;
    logic        wb_sel, dst_sel, rf_we, opa_sel;
    logic [1:0]  opb_sel, alu_mode, pc_src;
    logic [31:0] mem_rdata, mem_addr, mem_wdata;
    logic        mem_re, mem_we, zero;
    logic [5:0]  opcode;

    logic [31:0] mem [256];
    logic [31:0] model [32];
    logic [31:0] exp_pc, exp_target;
    int          n_checks = 0;
    int          n_fail = 0;
    bit          done = 1'b0;

    // 125 MHz: 8 time-unit period
    always #4 clk = ~clk;

    mc_datapath dut_i (
        .clk(clk), .rst_n(rst_n), .pc_we(pc_we), .pc_we_cond(pc_we_cond),
        .ir_we(ir_we), .addr_sel(addr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .wb_sel(wb_sel), .dst_sel(dst_sel), .rf_we(rf_we), .opa_sel(opa_sel),
        .opb_sel(opb_sel), .alu_mode(alu_mode), .pc_src(pc_src),
        .mem_rdata(mem_rdata), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_re(mem_re), .mem_we(mem_we), .opcode(opcode), .zero(zero)
    );

    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    task automatic idle_ctl();
        pc_we = 0; pc_we_cond = 0; ir_we = 0; addr_sel = 0; mem_rd = 0; mem_wr = 0;
        wb_sel = 0; dst_sel = 0; rf_we = 0; opa_sel = 0;
        opb_sel = 2'b00; alu_mode = 2'b00; pc_src = 2'b00;
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] imm);
        return {op, rs, rt, imm};
    endfunction

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] sx(input logic [15:0] imm);
        return {{16{imm[15]}}, imm};
    endfunction

    // Fetch then decode; bench owns the expected PC
    task automatic fetch_decode(input logic [31:0] insn);
        mem[exp_pc[9:2]] = insn;
        idle_ctl();
        ir_we = 1; mem_rd = 1; opb_sel = 2'b01; pc_we = 1;
        #1 chk("R5 fetch address is PC", mem_addr, exp_pc);
        tick();
        exp_pc = exp_pc + 4;
        chk("R6 opcode after fetch", {26'd0, opcode}, {26'd0, insn[31:26]});
        idle_ctl();
        opb_sel = 2'b11;
        #1 chk("R7 PC advanced by 4 (R2 R3)", mem_addr, exp_pc);
        exp_target = exp_pc + {sx(insn[15:0]) [29:0], 2'b00};
        tick();
    endtask

    task automatic run_lw(input logic [4:0] rt, input logic [4:0] rs, input logic [15:0] imm,
                          input logic [31:0] expv);
        logic [31:0] ea;
        ea = model[rs] + sx(imm);
        fetch_decode(enc_i(6'h23, rs, rt, imm));
        idle_ctl(); opa_sel = 1; opb_sel = 2'b10;
        tick();
        idle_ctl(); opa_sel = 1; opb_sel = 2'b10; addr_sel = 1; mem_rd = 1;
        #1 chk("R5 R11 load address from ALUOut", mem_addr, ea);
        chk("R5 read strobe", {31'd0, mem_re}, 32'd1);
        chk("R5 loaded word on port", mem_rdata, expv);
        tick();
        idle_ctl(); wb_sel = 1; rf_we = 1;
        tick();
        if (rt != 0) model[rt] = expv;
    endtask

    task automatic run_sw(input string req, input logic [4:0] rt, input logic [4:0] rs,
                          input logic [15:0] imm);
        logic [31:0] ea;
        ea = model[rs] + sx(imm);
        fetch_decode(enc_i(6'h2B, rs, rt, imm));
        idle_ctl(); opa_sel = 1; opb_sel = 2'b10;
        tick();
        idle_ctl(); addr_sel = 1; mem_wr = 1; opa_sel = 1; opb_sel = 2'b10;
        #1 chk({req, " R10 store data"}, mem_wdata, model[rt]);
        chk("R5 store address", mem_addr, ea);
        chk("R5 write strobe", {31'd0, mem_we}, 32'd1);
        tick();
        idle_ctl();
        chk({req, " stored word in memory"}, mem[ea[9:2]], model[rt]);
    endtask

    task automatic run_rtype(input logic [5:0] fn, input logic [4:0] rd, input logic [4:0] rs,
                             input logic [4:0] rt, input logic [31:0] expv);
        fetch_decode(enc_r(rs, rt, rd, fn));
        idle_ctl(); opa_sel = 1; opb_sel = 2'b00; alu_mode = 2'b10;
        #1 chk("R4 zero flag follows result", {31'd0, zero}, {31'd0, expv == 32'd0});
        tick();
        idle_ctl(); dst_sel = 1; rf_we = 1;
        tick();
        if (rd != 0) model[rd] = expv;
        run_sw("R4 R8 function result", rd, 5'd0, 16'h0200);
    endtask

    task automatic run_beq(input logic [4:0] rs, input logic [4:0] rt, input logic [15:0] off,
                           input bit taken);
        fetch_decode(enc_i(6'h04, rs, rt, off));
        idle_ctl(); opa_sel = 1; opb_sel = 2'b00; alu_mode = 2'b01; pc_src = 2'b01; pc_we_cond = 1;
        #1 chk("R4 zero on compare", {31'd0, zero}, {31'd0, taken});
        tick();
        if (taken) exp_pc = exp_target;
        idle_ctl();
        #1 chk(taken ? "R7 R3 branch taken target" : "R7 branch not taken holds PC", mem_addr, exp_pc);
    endtask

    task automatic run_jump(input logic [25:0] tgt);
        fetch_decode({6'h02, tgt});
        mem[tgt[7:0]] = 32'h8C00_0000;
        idle_ctl(); pc_src = 2'b10; pc_we = 1;
        tick();
        exp_pc = {exp_pc[31:28], tgt, 2'b00};
        idle_ctl();
        #1 chk("R7 jump address", mem_addr, exp_pc);
        tick(); tick();
        chk("R6 IR holds without ir_we", {26'd0, opcode}, 32'h0000_0002);
    endtask

    task automatic test_reset();
        idle_ctl();
        #1;
        chk("R1 reset PC on address", mem_addr, 32'd0);
        chk("R1 reset opcode", {26'd0, opcode}, 32'd0);
        chk("R1 reset B latch", mem_wdata, 32'd0);
        chk("R1 reset zero flag", {31'd0, zero}, 32'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        for (int i = 0; i < 32; i++) model[i] = 32'd0;
        mem[64] = 32'h0000_0007;
        mem[65] = 32'hFFFF_FFFD;
        mem[66] = 32'h1234_5678;
        mem[67] = 32'h0000_010C;
        exp_pc = 32'd0;
        idle_ctl();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();

        run_lw(5'd1, 5'd0, 16'h0100, 32'h0000_0007);
        run_lw(5'd2, 5'd0, 16'h0104, 32'hFFFF_FFFD);
        run_lw(5'd4, 5'd0, 16'h010C, 32'h0000_010C);
        run_lw(5'd3, 5'd4, 16'hFFFC, 32'h1234_5678);        // R11 negative offset
        run_sw("R8 R11 load via negative offset", 5'd3, 5'd0, 16'h01F8);

        run_rtype(6'h20, 5'd5,  5'd1, 5'd2, 32'h0000_0004);
        run_rtype(6'h22, 5'd6,  5'd1, 5'd2, 32'h0000_000A);
        run_rtype(6'h24, 5'd7,  5'd1, 5'd2, 32'h0000_0005);
        run_rtype(6'h25, 5'd8,  5'd1, 5'd2, 32'hFFFF_FFFF);
        run_rtype(6'h26, 5'd11, 5'd1, 5'd2, 32'hFFFF_FFFA);
        run_rtype(6'h27, 5'd12, 5'd1, 5'd2, 32'h0000_0000);
        run_rtype(6'h2A, 5'd9,  5'd2, 5'd1, 32'h0000_0001);
        run_rtype(6'h2A, 5'd10, 5'd1, 5'd2, 32'h0000_0000);
        run_rtype(6'h3F, 5'd13, 5'd1, 5'd1, 32'h0000_000E);   // unlisted code adds

        run_sw("R8 rt of function untouched", 5'd2, 5'd0, 16'h0204);

        run_lw(5'd0, 5'd0, 16'h0100, 32'h0000_0007);
        run_sw("R9 register 0 write ignored", 5'd0, 5'd0, 16'h0208);

        run_beq(5'd1, 5'd1, 16'h0002, 1'b1);
        run_beq(5'd1, 5'd2, 16'h0003, 1'b0);
        run_jump(26'h000_0030);

        done = 1'b1;
        summary();
    end

endmodule